// File: doc/BRIEF.md
# Host Recovery Doorbell Register Block

This block is the peripheral end of a keyboard-controller-style byte interface between a host and a local controller. It is used as a minimal recovery doorbell. The host has one I/O port with a command/data select. A host write drops a byte into the inbound data register and raises an inbound-full flag. The local side drains the byte through its own register port. The host learns about progress only by polling the status byte, so no host interrupt exists.

The status byte mixes flags owned by the hardware with bits owned by software. The hardware owns inbound-full, outbound-full and command/data. Software owns an Alive flag and four spare bits. The local side reads the inbound register to consume a byte. If the consumed byte equals the debug code (0x44 by default), the block emits a one-cycle debug request, which a recovery agent turns into a dump and reboot. Any other byte is dropped, and the block simply waits for the next one. A level interrupt to the local side follows inbound-full, gated by an enable bit.

Top module: `kcs_recovery_port`

## Requirements
- R1: A synchronous reset (`rst` high) clears the inbound and outbound data registers, every status bit (including Alive) and the interrupt enable, so the status byte reads 0x00 and `loc_irq` and `dbg_req` are low.
- R2: A host write (`host_wr`) stores `host_wdata` in the inbound register and sets inbound-full (status bit 1) on the next cycle. In the same cycle, command/data (status bit 3) becomes 1 if `host_cmd_sel` was 1 and 0 if it was 0.
- R3: A local read at address 0 returns the inbound byte combinationally and clears inbound-full on the next cycle. If a host write lands in the same cycle, inbound-full stays set and the new byte is stored.
- R4: A local write at address 0 loads the outbound register and sets outbound-full (status bit 0). A host read with `host_cmd_sel` 0 returns the outbound byte and clears outbound-full, unless a local write to address 0 happens in the same cycle.
- R5: A local write at address 1 sets status bits 7, 6, 5, 4 (Alive) and 2 from `loc_wdata`. It has no effect on bits 3, 1 and 0. No other access changes bits 7, 6, 5, 4 or 2.
- R6: `dbg_req` is high for exactly the cycle after a local read at address 0 that is made while inbound-full is set and the inbound byte equals the debug code. A read of any other byte, or a read while inbound-full is clear, gives no pulse.
- R7: `loc_irq` is high exactly while inbound-full is set and the enable (bit 0 of local address 2, readable back there) is 1.
- R8: `host_rdata` shows the status byte whenever `host_cmd_sel` is 1. A host read there has no side effects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_cmd_sel | input | 1 | 1 selects the command/status address, 0 selects the data address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Status byte or outbound byte |
| loc_wr | input | 1 | Local write strobe |
| loc_rd | input | 1 | Local read strobe |
| loc_addr | input | 2 | 0 data, 1 status, 2 control, 3 unused |
| loc_wdata | input | 8 | Local write byte |
| loc_rdata | output | 8 | Local read byte |
| loc_irq | output | 1 | Inbound-full interrupt, level |
| dbg_req | output | 1 | One-cycle debug request |

## Verification
The bench targets the trigger path in three cases. The first reads 0x44 with inbound-full clear, which a design that only compares the byte would wrongly pulse. The second reads a neighbouring value, which a loose compare would accept. The third reads the same stale byte twice, which a design that forgets to clear inbound-full would pulse again. It also drives collisions: a host write together with a local drain, and a local outbound write together with a host drain. A design with the wrong priority in either case would lose a byte's full flag. Local writes of 0xFF to the status address check that the hardware-owned bits cannot be forced, and polls at the command address check that reading status never disturbs it.

// File: rtl/kcs_recovery_port.sv
module kcs_recovery_port #(
  parameter logic [7:0] DEBUG_CODE = 8'h44
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic       host_cmd_sel,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       loc_wr,
  input  logic       loc_rd,
  input  logic [1:0] loc_addr,
  input  logic [7:0] loc_wdata,
  output logic [7:0] loc_rdata,
  output logic       loc_irq,
  output logic       dbg_req
);
  localparam logic [1:0] LA_DATA = 2'd0;
  localparam logic [1:0] LA_STAT = 2'd1;
  localparam logic [1:0] LA_CTRL = 2'd2;
  localparam logic [7:0] SW_MASK = 8'hF4;

  logic [7:0] idr, odr, sw_bits;
  logic       ibf, obf, cd, ien;
  logic [7:0] status;

  wire loc_drain = loc_rd && loc_addr == LA_DATA;
  wire loc_fill  = loc_wr && loc_addr == LA_DATA;
  wire host_drain = host_rd && !host_cmd_sel;

  assign status     = sw_bits | {4'b0, cd, 1'b0, ibf, obf};
  assign host_rdata = host_cmd_sel ? status : odr;
  assign loc_irq    = ibf && ien;

  always_comb begin
    case (loc_addr)
      LA_DATA: loc_rdata = idr;
      LA_STAT: loc_rdata = status;
      LA_CTRL: loc_rdata = {7'b0, ien};
      default: loc_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idr <= '0; odr <= '0; sw_bits <= '0;
      ibf <= 1'b0; obf <= 1'b0; cd <= 1'b0; ien <= 1'b0;
      dbg_req <= 1'b0;
    end else begin
      dbg_req <= loc_drain && ibf && idr == DEBUG_CODE;
      if (host_wr) begin
        idr <= host_wdata;
        cd  <= host_cmd_sel;
        ibf <= 1'b1;
      end else if (loc_drain) begin
        ibf <= 1'b0;
      end
      if (loc_fill) begin
        odr <= loc_wdata;
        obf <= 1'b1;
      end else if (host_drain) begin
        obf <= 1'b0;
      end
      if (loc_wr && loc_addr == LA_STAT) sw_bits <= loc_wdata & SW_MASK;
      if (loc_wr && loc_addr == LA_CTRL) ien <= loc_wdata[0];
    end
  end

  a_r2_host_write_sets_full: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> (status[1] && status[3] == $past(host_cmd_sel)));
  a_r3_drain_clears_full: assert property (@(posedge clk) disable iff (rst)
    (loc_drain && !host_wr) |=> !status[1]);
  a_r4_fill_sets_obf: assert property (@(posedge clk) disable iff (rst)
    loc_fill |=> status[0]);
  a_r5_sw_bits_hold: assert property (@(posedge clk) disable iff (rst)
    !(loc_wr && loc_addr == LA_STAT) |=> $stable(status & SW_MASK));
  a_r6_pulse_needs_full: assert property (@(posedge clk) disable iff (rst)
    dbg_req |-> $past(status[1]));
  a_r7_irq_follows_full: assert property (@(posedge clk) disable iff (rst)
    loc_irq |-> status[1]);
endmodule

// File: tb/test_kcs_recovery_port.sv
module test_kcs_recovery_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 0, host_rd = 0, host_cmd_sel = 1;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic loc_wr = 0, loc_rd = 0;
  logic [1:0] loc_addr = 0;
  logic [7:0] loc_wdata = 0;
  logic [7:0] loc_rdata;
  logic loc_irq, dbg_req;

  int total = 0, bad = 0;
  logic [7:0] m_idr = 0, m_odr = 0, m_sw = 0;
  logic m_ibf = 0, m_obf = 0, m_cd = 0, m_ien = 0, m_pulse = 0;

  always #4 clk = ~clk;

  kcs_recovery_port i_kcs_recovery_port (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_cmd_sel(host_cmd_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .loc_wr(loc_wr), .loc_rd(loc_rd), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .loc_rdata(loc_rdata), .loc_irq(loc_irq), .dbg_req(dbg_req));

  function automatic logic [7:0] exp_status();
    return (m_sw & 8'hF4) | {4'b0, m_cd, 1'b0, m_ibf, m_obf};
  endfunction

  function automatic logic [7:0] exp_loc(logic [1:0] a);
    case (a)
      2'd0: return m_idr;
      2'd1: return exp_status();
      2'd2: return {7'b0, m_ien};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(logic hw, logic hr, logic hc, logic [7:0] hd,
                      logic lw, logic lr, logic [1:0] la, logic [7:0] ld);
    logic n_ibf, n_obf;
    @(negedge clk);
    host_wr = hw; host_rd = hr; host_cmd_sel = hc; host_wdata = hd;
    loc_wr = lw; loc_rd = lr; loc_addr = la; loc_wdata = ld;
    #1;
    if (lr) check(la == 2'd0 ? "R3 local data read" : "R7/R5 local read", loc_rdata, exp_loc(la));
    if (hr && !hc) check("R4 host data read", host_rdata, m_odr);
    if (hc) check("R8 host status view", host_rdata, exp_status());
    m_pulse = lr && la == 2'd0 && m_ibf && m_idr == 8'h44;
    n_ibf = hw ? 1'b1 : ((lr && la == 2'd0) ? 1'b0 : m_ibf);
    n_obf = (lw && la == 2'd0) ? 1'b1 : ((hr && !hc) ? 1'b0 : m_obf);
    if (hw) begin m_idr = hd; m_cd = hc; end
    if (lw && la == 2'd0) m_odr = ld;
    if (lw && la == 2'd1) m_sw = ld & 8'hF4;
    if (lw && la == 2'd2) m_ien = ld[0];
    m_ibf = n_ibf; m_obf = n_obf;
    @(posedge clk); #1;
    host_wr = 0; host_rd = 0; host_cmd_sel = 1; loc_wr = 0; loc_rd = 0;
    #1;
    check("R2/R5 status after op", host_rdata, exp_status());
    check("R6 debug pulse", {7'b0, dbg_req}, {7'b0, m_pulse});
    check("R7 interrupt level", {7'b0, loc_irq}, {7'b0, m_ibf && m_ien});
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (2) @(posedge clk);
    // R1 reset state after dirtying the registers
    rst = 0;
    step(1, 0, 1, 8'h44, 1, 0, 2'd1, 8'hFF);
    step(0, 0, 0, 0, 1, 0, 2'd2, 8'h01);
    @(negedge clk); rst = 1; @(posedge clk); #1; rst = 0; #1;
    m_idr = 0; m_odr = 0; m_sw = 0; m_ibf = 0; m_obf = 0; m_cd = 0; m_ien = 0;
    check("R1 status after reset", host_rdata, 8'h00);
    check("R1 irq after reset", {7'b0, loc_irq}, 8'h00);
    check("R1 pulse after reset", {7'b0, dbg_req}, 8'h00);
    loc_addr = 0; #1;
    check("R1 inbound cleared", loc_rdata, 8'h00);
    // R6 directed trigger cases
    step(0, 0, 0, 0, 1, 0, 2'd2, 8'h01);
    step(1, 0, 0, 8'h44, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 2'd0, 0);
    step(0, 0, 0, 0, 0, 1, 2'd0, 0);
    step(1, 0, 1, 8'h45, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 2'd0, 0);
    // R3 collision: host write with local drain
    step(1, 0, 0, 8'h44, 0, 0, 0, 0);
    step(1, 0, 1, 8'h12, 0, 1, 2'd0, 0);
    step(0, 0, 0, 0, 0, 1, 2'd0, 0);
    // R4 collision: local fill with host drain
    step(0, 0, 0, 0, 1, 0, 2'd0, 8'hA5);
    step(0, 1, 0, 0, 1, 0, 2'd0, 8'h5A);
    step(0, 1, 0, 0, 0, 0, 0, 0);
    // R5 hardware bits not writable, Alive set and cleared
    step(0, 0, 0, 0, 1, 0, 2'd1, 8'hFF);
    step(0, 0, 0, 0, 1, 0, 2'd1, 8'h0B);
    // R8 status polls are side-effect free
    step(1, 0, 1, 8'h33, 0, 0, 0, 0);
    step(0, 1, 1, 0, 0, 0, 0, 0);
    step(0, 1, 1, 0, 0, 1, 2'd1, 0);
    for (int i = 0; i < 600; i++) begin
      logic [7:0] hd;
      hd = ($urandom % 3 == 0) ? 8'h44 : 8'($urandom);
      step(($urandom % 4) == 0, ($urandom % 4) == 0, 1'($urandom), hd,
           ($urandom % 5) == 0, ($urandom % 3) == 0, 2'($urandom), 8'($urandom));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule